// File: doc/BRIEF.md
# Configuration Word Stream Parser

This block watches a stream of 32-bit configuration words, each qualified by a valid strobe, and decodes a small bitstream format that does not depend on device location. A reconfiguration phase opens on a sync word and closes on a desync command. Inside the phase, the block takes a region ID and a module ID from the frame-address write and sends them to a region selector with a one-cycle strobe. It also counts the payload words of a frame-data write, so that error injection can be timed against them.

Outside a phase the block ignores every word. Inside a phase, a header it does not know is skipped as a single word and sets a sticky error flag. All outputs are driven from registered state, so each one reflects the last valid word from the clock edge that accepted that word.

Top module: `cfg_stream_parser`

## Requirements
- R1: After reset, every output is low or zero.
- R2: The word 0xAA995566 opens the phase, and `in_reconf_o` goes high after the edge that takes it. Before that word, all other words are ignored.
- R3: After the header 0x30002001, the next valid word drives its bits 31:24 onto `sel_region_o` and its bits 23:16 onto `sel_module_o`, and `sel_stb_o` is high for exactly one cycle. Both IDs keep their values between strobes.
- R4: Inside the phase, the word 0x20000000 changes no output.
- R5: After the header 0x30008001, a value of 0x0000000D closes the phase: `in_reconf_o` drops and `end_stb_o` pulses for one cycle. A value of 0x00000001 changes no output.
- R6: After the header 0x30004000, a word whose bits 31:27 are 01010 gives a count N in bits 26:0. `payload_o` is then high for exactly the next N valid words, whatever their content, and N = 0 gives no payload cycles.
- R7: After the phase closes, every word other than the sync word is ignored.
- R8: Each of these sets `err_o`, which stays high until reset: an unknown header inside the phase, a command value other than 1 or 0xD, or a word other than a count word after 0x30004000. The offending word is consumed as a single word.
- R9: Cycles with `word_vld_i` low change no state, and both strobes are low in the cycle after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 32 | Configuration word |
| word_vld_i | input | 1 | Word valid |
| in_reconf_o | output | 1 | Reconfiguration phase active |
| sel_stb_o | output | 1 | Module-select strobe |
| sel_region_o | output | 8 | Selected region ID |
| sel_module_o | output | 8 | Selected module ID |
| payload_o | output | 1 | Payload words being written |
| end_stb_o | output | 1 | End-of-reconfiguration strobe |
| err_o | output | 1 | Sticky format error |

## Verification
The assertions take for granted that `word_vld_i` and `word_i` are clean at each rising edge and that reset is held for at least one edge. They do not require the stream to be well formed, so malformed headers, bad counts and gaps are all legal inputs. The stimulus mixes well-formed sequences with random garbage and random valid gaps. Payload counts are kept small so that payload windows end inside the run.

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser #(
  parameter int CNTW = 27
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] word_i,
  input  logic        word_vld_i,
  output logic        in_reconf_o,
  output logic        sel_stb_o,
  output logic [7:0]  sel_region_o,
  output logic [7:0]  sel_module_o,
  output logic        payload_o,
  output logic        end_stb_o,
  output logic        err_o
);
  localparam logic [31:0] W_SYNC  = 32'hAA995566;
  localparam logic [31:0] W_NOP   = 32'h20000000;
  localparam logic [31:0] H_ADDR  = 32'h30002001;
  localparam logic [31:0] H_CMD   = 32'h30008001;
  localparam logic [31:0] H_DATA  = 32'h30004000;
  localparam logic [31:0] C_WCFG  = 32'h00000001;
  localparam logic [31:0] C_DSYNC = 32'h0000000D;
  localparam logic [4:0]  T2_TAG  = 5'b01010;

  typedef enum logic [2:0] {S_OFF, S_HDR, S_ADDR, S_CMD, S_CNT, S_PAY} st_t;

  st_t             st;
  logic [CNTW-1:0] left;
  logic [CNTW-1:0] cnt_in;

  assign cnt_in      = word_i[CNTW-1:0];
  assign in_reconf_o = (st != S_OFF);
  assign payload_o   = (st == S_PAY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_OFF;
      left         <= '0;
      sel_stb_o    <= 1'b0;
      end_stb_o    <= 1'b0;
      sel_region_o <= '0;
      sel_module_o <= '0;
      err_o        <= 1'b0;
    end else begin
      sel_stb_o <= 1'b0;
      end_stb_o <= 1'b0;
      if (word_vld_i) begin
        case (st)
          S_OFF: if (word_i == W_SYNC) st <= S_HDR;
          S_HDR: begin
            if      (word_i == H_ADDR) st <= S_ADDR;
            else if (word_i == H_CMD)  st <= S_CMD;
            else if (word_i == H_DATA) st <= S_CNT;
            else if (word_i != W_NOP)  err_o <= 1'b1;
          end
          S_ADDR: begin
            sel_region_o <= word_i[31:24];
            sel_module_o <= word_i[23:16];
            sel_stb_o    <= 1'b1;
            st           <= S_HDR;
          end
          S_CMD: begin
            if (word_i == C_DSYNC) begin
              end_stb_o <= 1'b1;
              st        <= S_OFF;
            end else begin
              if (word_i != C_WCFG) err_o <= 1'b1;
              st <= S_HDR;
            end
          end
          S_CNT: begin
            if (word_i[31:27] == T2_TAG) begin
              left <= cnt_in;
              st   <= (cnt_in == '0) ? S_HDR : S_PAY;
            end else begin
              err_o <= 1'b1;
              st    <= S_HDR;
            end
          end
          S_PAY: begin
            left <= left - 1'b1;
            if (left == {{(CNTW-1){1'b0}}, 1'b1}) st <= S_HDR;
          end
          default: st <= S_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_stream_parser_chk.sv
module cfg_stream_parser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       word_vld_i,
  input logic       in_reconf_o,
  input logic       sel_stb_o,
  input logic [7:0] sel_region_o,
  input logic [7:0] sel_module_o,
  input logic       payload_o,
  input logic       end_stb_o,
  input logic       err_o
);
  a_r2_open_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_reconf_o) |-> $past(word_vld_i));
  a_r3_strobe_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb_o |-> in_reconf_o);
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb_o |=> !sel_stb_o);
  a_r3_ids_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_stb_o |-> ($stable(sel_region_o) && $stable(sel_module_o)));
  a_r5_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
    end_stb_o |-> (!in_reconf_o && $past(in_reconf_o)));
  a_r6_payload_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    payload_o |-> in_reconf_o);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_i |=> (!sel_stb_o && !end_stb_o && $stable(in_reconf_o) && $stable(payload_o)));
endmodule

bind cfg_stream_parser cfg_stream_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_vld_i(word_vld_i),
  .in_reconf_o(in_reconf_o), .sel_stb_o(sel_stb_o),
  .sel_region_o(sel_region_o), .sel_module_o(sel_module_o),
  .payload_o(payload_o), .end_stb_o(end_stb_o), .err_o(err_o)
);

// File: tb/tb_cfg_stream_parser.sv
module tb_cfg_stream_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_vld_i = 1'b0;
  logic        in_reconf_o, sel_stb_o, payload_o, end_stb_o, err_o;
  logic [7:0]  sel_region_o, sel_module_o;

  always #2 clk = ~clk;

  cfg_stream_parser dut (.*);

  int nvec = 0, nbad = 0;
  int ms = 0;
  int mleft = 0;
  logic m_in, m_sel, m_pay, m_end, m_err;
  logic [7:0] m_reg, m_mod;

  function automatic bit is_t2(input logic [31:0] w);
    return w[31:27] == 5'b01010;
  endfunction

  task automatic model_reset();
    ms = 0; mleft = 0; m_sel = 0; m_end = 0; m_err = 0; m_reg = 0; m_mod = 0;
  endtask

  task automatic model_step(input logic [31:0] w, input logic v);
    m_sel = 0; m_end = 0;
    if (v) begin
      case (ms)
        0: if (w == 32'hAA995566) ms = 1;
        1: if (w == 32'h30002001) ms = 2;
           else if (w == 32'h30008001) ms = 3;
           else if (w == 32'h30004000) ms = 4;
           else if (w != 32'h20000000) m_err = 1;
        2: begin m_reg = w[31:24]; m_mod = w[23:16]; m_sel = 1; ms = 1; end
        3: if (w == 32'h0000000D) begin m_end = 1; ms = 0; end
           else begin if (w != 32'h1) m_err = 1; ms = 1; end
        4: if (is_t2(w)) begin mleft = int'(w[26:0]); ms = (mleft == 0) ? 1 : 5; end
           else begin m_err = 1; ms = 1; end
        default: begin mleft--; if (mleft == 0) ms = 1; end
      endcase
    end
    m_in = (ms != 0);
    m_pay = (ms == 5);
  endtask

  task automatic cmp1(input string tag, input string f, input int a, input int e);
    if (a != e) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, f, a, e);
    end
  endtask

  task automatic check(input string tag);
    int b;
    b = nbad;
    nvec++;
    cmp1(tag, "in_reconf", in_reconf_o, m_in);
    cmp1(tag, "sel_stb", sel_stb_o, m_sel);
    cmp1(tag, "region", sel_region_o, m_reg);
    cmp1(tag, "module", sel_module_o, m_mod);
    cmp1(tag, "payload", payload_o, m_pay);
    cmp1(tag, "end_stb", end_stb_o, m_end);
    cmp1(tag, "err", err_o, m_err);
    if (nbad > b) nbad = b + 1;
  endtask

  task automatic send(input logic [31:0] w, input logic v, input string tag);
    @(negedge clk);
    word_i = w; word_vld_i = v;
    @(posedge clk);
    model_step(w, v);
    #1 check(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; word_vld_i = 0;
    @(posedge clk); @(posedge clk);
    model_reset(); m_in = 0; m_pay = 0;
    #1 check("R1");
    @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [31:0] rnd_word();
    case ($urandom_range(0, 9))
      0: return 32'hAA995566;
      1: return 32'h20000000;
      2: return 32'h30002001;
      3: return 32'h30008001;
      4: return 32'h30004000;
      5: return 32'h50000000 | $urandom_range(0, 5);
      6: return 32'h0000000D;
      7: return 32'h00000001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    do_reset();
    // R2: junk before sync is ignored, then sync opens
    send(32'h30002001, 1, "R2");
    send(32'h01020000, 1, "R2");
    send(32'h12345678, 1, "R2");
    send(32'hAA995566, 1, "R2");
    send(32'h20000000, 1, "R4");
    send(32'h30002001, 1, "R3");
    send(32'h01020000, 1, "R3");
    send(32'h0, 0, "R9");
    send(32'h30008001, 1, "R5");
    send(32'h00000001, 1, "R5");
    send(32'h30004000, 1, "R6");
    send(32'h50000004, 1, "R6");
    send(32'h30002001, 1, "R6");
    send(32'h0, 0, "R9");
    send(32'hFFFF0000, 1, "R6");
    send(32'h0000000D, 1, "R6");
    send(32'h5650EEA7, 1, "R6");
    send(32'h30004000, 1, "R6");
    send(32'h50000000, 1, "R6");
    send(32'h20000000, 1, "R6");
    send(32'h30008001, 1, "R5");
    send(32'h0000000D, 1, "R5");
    send(32'h0, 0, "R9");
    send(32'h30002001, 1, "R7");
    send(32'hAB000000, 1, "R7");
    send(32'hDEADBEEF, 1, "R7");
    send(32'hAA995566, 1, "R2");
    send(32'h30004000, 1, "R6");
    send(32'hF8000002, 1, "R6"); // bits 26:0 = 2, tag bits 31:27 = 01010 needed
    send(32'h0, 0, "R9");
    send(32'hCAFEF00D, 1, "R8");
    send(32'h30008001, 1, "R8");
    send(32'h00000007, 1, "R8");
    send(32'h20000000, 1, "R8");
    do_reset();
    send(32'hAA995566, 1, "R2");
    send(32'h30004000, 1, "R6");
    send(32'h5800_0003, 1, "R6"); // tag 01011 is not a count word
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if (i % 700 == 699) do_reset();
      send(rnd_word(), ($urandom_range(0, 4) != 0), "R8");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule